// File: doc/BRIEF.md
# SECDED Memory Protection with Error Poisoning

This block sits between a plain write/read request port and a 72-bit-wide storage array. Each 64-bit write is extended with seven Hamming check bits and one overall parity bit before it reaches the array. Each word that comes back from the array is checked. A single flipped bit is repaired before the data is returned. Two flipped bits are reported as uncorrectable, both on the read response and as an interrupt.

For fault testing, software can arm a one-shot poison. The poison has a mode, which is either single-bit or double-bit, and a target address. The next write to exactly that address stores a deliberately damaged word. The damage shows up when that address is read later.

Every error event overwrites a small record that holds the type, the syndrome and the address of the event. Every error event also bumps a saturating per-type counter and raises a level interrupt. Software clears the interrupt by writing one to the status register.

Top module: `ecc_guard`

## Requirements
- R1: A write request (`wr_req`) shows up on the array port one cycle later, with `mem_we` set. The stored word is laid out as follows. Bits [63:0] hold the data. Bits [70:64] hold check bits c0..c6. Bit 71 makes the whole 72-bit word even parity. To form the check bits, Hamming positions 1..71 that are not powers of two are given to data bits 0..63 in ascending order. Check bit cj is the XOR of the data bits whose position has bit j set.
- R2: The array answers `mem_re` with `mem_rvalid`. One cycle after `mem_rvalid`, `rsp_valid` pulses for one cycle. If the word is clean, `rsp_data` equals the stored data, `rsp_err` is 0, and no error event is recorded.
- R3: If any one of the 72 stored bits is flipped, the read returns the original data with `rsp_err`=0 and records a correctable event.
- R4: If two stored bits are flipped, the read sets `rsp_err`=1, returns the raw stored data bits, records an uncorrectable event, and raises `irq`.
- R5: The syndrome is s, the recomputed check bits XOR the stored check bits, and p is the XOR of all 72 bits. The cases are decoded as follows:
  - s=0 and p=0 means no error.
  - p=1 and s<=71 means correctable. This case includes s=0, which is an error in the parity bit alone.
  - p=1 and s>71 means uncorrectable.
  - p=0 and s!=0 means uncorrectable.
  - The recorded syndrome field is {p, s}.
- R6: Writing 1 to `cfg_wdata[1:0]` at `cfg_addr` 0 arms single-bit poison. Writing 2 arms double-bit poison. The check bits of the poisoned write come from the clean data. Data bit 0 is then flipped for single-bit poison, and data bits 0 and 1 are flipped for double-bit poison.
- R7: The poison is applied only to a write whose address equals the poison target at `cfg_addr` 1. Writes to other addresses are stored clean, and the poison stays armed.
- R8: A matching write disarms the poison. Writing 0 or 3 to the mode field also disarms it. Reading `cfg_addr` 0 returns the mode in bits [1:0] and the armed flag in bit 2.
- R9: At each error event, `cfg_addr` 2 records the following: bit 1 is the type (1 = uncorrectable) and bits [15:8] hold {p, s}. At the same event, `cfg_addr` 3 records the read address. A clean read leaves the record as it was.
- R10: Any error event sets `irq`, which also reads back as bit 0 of `cfg_addr` 2. `irq` stays set until a write to `cfg_addr` 2 with bit 0 set clears it. If an event and a clear happen in the same cycle, the event wins.
- R11: `cfg_addr` 4 holds the correctable count in bits [15:0] and the uncorrectable count in bits [31:16]. Each counter is CNT_W bits wide and stops at its maximum value.
- R12: After reset, `mem_we`, `rsp_valid` and `irq` are 0, and configuration addresses 0 to 4 all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 64 | Write data |
| rd_req | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 64 | Corrected read data |
| rsp_err | output | 1 | Uncorrectable error on this response |
| mem_we | output | 1 | Array write enable |
| mem_waddr | output | ADDR_W | Array write address |
| mem_wcode | output | 72 | Array write codeword |
| mem_re | output | 1 | Array read enable |
| mem_raddr | output | ADDR_W | Array read address |
| mem_rvalid | input | 1 | Array read data valid |
| mem_rcode | input | 72 | Array read codeword |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| irq | output | 1 | Error interrupt |

## Verification
The bench builds the block with ADDR_W=8, so the storage model covers every address with a 256-entry array. It uses CNT_W=4, so the correctable counter reaches its limit of 15 during the sweep that flips each of the 72 stored bits in turn. Saturation therefore becomes visible within a few hundred cycles, instead of after 65535 events. The bench also exercises the following cases:
- double flips that touch the check and parity bits;
- a triple flip whose syndrome falls outside positions 1..71;
- both poison flavours, including a write to a non-matching address while the poison is armed.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int DATA_W   = 64;
    localparam int CHK_W    = 7;
    localparam int LAST_POS = DATA_W + CHK_W;
    localparam int CODE_W   = LAST_POS + 1;
    localparam int SYN_W    = CHK_W + 1;

    typedef enum logic [1:0] {
        PZ_OFF    = 2'd0,
        PZ_SINGLE = 2'd1,
        PZ_DOUBLE = 2'd2,
        PZ_RSVD   = 2'd3
    } pz_mode_e;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_CORR   = 2'd1,
        EV_UNCORR = 2'd2
    } ev_kind_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        ev_kind_e          kind;
        logic [SYN_W-1:0]  syn;
    } dec_res_t;

    // XOR of the Hamming positions of all set data bits
    function automatic logic [CHK_W-1:0] pos_xor(input logic [DATA_W-1:0] d);
        logic [CHK_W-1:0] acc;
        int k;
        acc = '0;
        k   = 0;
        for (int p = 1; p <= LAST_POS; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (d[k]) acc ^= p[CHK_W-1:0];
                k++;
            end
        end
        return acc;
    endfunction

    // one-hot data mask for the data bit living at Hamming position s
    function automatic logic [DATA_W-1:0] pos_mask(input logic [CHK_W-1:0] s);
        logic [DATA_W-1:0] m;
        int k;
        m = '0;
        k = 0;
        for (int p = 1; p <= LAST_POS; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (p[CHK_W-1:0] == s) m[k] = 1'b1;
                k++;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CODE_W-1:0] code
);
    logic [CHK_W-1:0] chk;

    always_comb begin
        chk  = pos_xor(data);
        code = {^{chk, data}, chk, data};
    end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import ecc_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output dec_res_t          res
);
    logic [CHK_W-1:0] s;
    logic             par;

    always_comb begin
        s        = pos_xor(code[DATA_W-1:0]) ^ code[LAST_POS-1:DATA_W];
        par      = ^code;
        res.data = code[DATA_W-1:0];
        res.syn  = {par, s};
        res.kind = EV_NONE;
        if (par) begin
            if (int'(s) <= LAST_POS) begin
                res.kind = EV_CORR;
                res.data = code[DATA_W-1:0] ^ pos_mask(s);
            end else begin
                res.kind = EV_UNCORR;
            end
        end else if (s != '0) begin
            res.kind = EV_UNCORR;
        end
    end
endmodule

// File: rtl/poison_ctl.sv
module poison_ctl
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  pz_mode_e          mode_in,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    output pz_mode_e          mode,
    output logic              armed,
    output logic [ADDR_W-1:0] target,
    output logic [DATA_W-1:0] inj_mask
);
    logic hit;

    always_comb begin
        hit      = armed && wr_fire && (wr_addr == target);
        inj_mask = '0;
        if (hit) begin
            if (mode == PZ_DOUBLE)      inj_mask[1:0] = 2'b11;
            else if (mode == PZ_SINGLE) inj_mask[0]   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= PZ_OFF;
            armed  <= 1'b0;
            target <= '0;
        end else begin
            if (addr_we) target <= addr_in;
            if (mode_we) begin
                mode  <= mode_in;
                armed <= (mode_in == PZ_SINGLE) || (mode_in == PZ_DOUBLE);
            end else if (hit) begin
                armed <= 1'b0;
            end
        end
    end

    // R8: a matching write leaves the poison disarmed
    p_one_shot_r8: assert property (@(posedge clk) disable iff (rst)
        (hit && !mode_we) |=> !armed);
endmodule

// File: rtl/err_log.sv
module err_log
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  ev_kind_e          ev_kind,
    input  logic [SYN_W-1:0]  ev_syn,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              clr,
    output logic              irq,
    output logic              last_ue,
    output logic [SYN_W-1:0]  last_syn,
    output logic [ADDR_W-1:0] last_addr,
    output logic [CNT_W-1:0]  ce_cnt,
    output logic [CNT_W-1:0]  ue_cnt
);
    logic hit;
    assign hit = ev_valid && (ev_kind != EV_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq       <= 1'b0;
            last_ue   <= 1'b0;
            last_syn  <= '0;
            last_addr <= '0;
            ce_cnt    <= '0;
            ue_cnt    <= '0;
        end else begin
            if (hit) begin
                irq       <= 1'b1;
                last_ue   <= (ev_kind == EV_UNCORR);
                last_syn  <= ev_syn;
                last_addr <= ev_addr;
                if (ev_kind == EV_CORR && ce_cnt != '1)   ce_cnt <= ce_cnt + 1'b1;
                if (ev_kind == EV_UNCORR && ue_cnt != '1) ue_cnt <= ue_cnt + 1'b1;
            end else if (clr) begin
                irq <= 1'b0;
            end
        end
    end

    p_irq_set_r10: assert property (@(posedge clk) disable iff (rst)
        hit |=> irq);
    p_irq_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> irq);
    p_ce_sat_r11: assert property (@(posedge clk) disable iff (rst)
        (ce_cnt == '1) |=> (ce_cnt == '1));
    p_ue_sat_r11: assert property (@(posedge clk) disable iff (rst)
        (ue_cnt == '1) |=> (ue_cnt == '1));
endmodule

// File: rtl/ecc_guard.sv
module ecc_guard
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [63:0]       wr_data,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rsp_valid,
    output logic [63:0]       rsp_data,
    output logic              rsp_err,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [71:0]       mem_wcode,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic              mem_rvalid,
    input  logic [71:0]       mem_rcode,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              irq
);
    localparam int PAD_W = CODE_W - DATA_W;

    logic [CODE_W-1:0] enc_code;
    logic [DATA_W-1:0] inj_mask;
    pz_mode_e          pz_mode;
    logic              pz_armed;
    logic [ADDR_W-1:0] pz_target;
    dec_res_t          dec;
    logic [ADDR_W-1:0] pend_addr;
    logic              last_ue;
    logic [SYN_W-1:0]  last_syn;
    logic [ADDR_W-1:0] last_addr;
    logic [CNT_W-1:0]  ce_cnt, ue_cnt;
    logic              mode_we, tgt_we, irq_clr;

    assign mode_we = cfg_we && (cfg_addr == 3'd0);
    assign tgt_we  = cfg_we && (cfg_addr == 3'd1);
    assign irq_clr = cfg_we && (cfg_addr == 3'd2) && cfg_wdata[0];

    secded_enc u_enc (.data(wr_data), .code(enc_code));

    poison_ctl #(.ADDR_W(ADDR_W)) u_poison (
        .clk(clk), .rst(rst),
        .mode_we(mode_we), .mode_in(pz_mode_e'(cfg_wdata[1:0])),
        .addr_we(tgt_we), .addr_in(cfg_wdata[ADDR_W-1:0]),
        .wr_fire(wr_req), .wr_addr(wr_addr),
        .mode(pz_mode), .armed(pz_armed), .target(pz_target),
        .inj_mask(inj_mask)
    );

    secded_dec u_dec (.code(mem_rcode), .res(dec));

    err_log #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_log (
        .clk(clk), .rst(rst),
        .ev_valid(mem_rvalid), .ev_kind(dec.kind), .ev_syn(dec.syn),
        .ev_addr(pend_addr), .clr(irq_clr),
        .irq(irq), .last_ue(last_ue), .last_syn(last_syn),
        .last_addr(last_addr), .ce_cnt(ce_cnt), .ue_cnt(ue_cnt)
    );

    assign mem_re    = rd_req;
    assign mem_raddr = rd_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we    <= 1'b0;
            mem_waddr <= '0;
            mem_wcode <= '0;
            pend_addr <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_err   <= 1'b0;
        end else begin
            mem_we <= wr_req;
            if (wr_req) begin
                mem_waddr <= wr_addr;
                mem_wcode <= enc_code ^ {{PAD_W{1'b0}}, inj_mask};
            end
            if (rd_req) pend_addr <= rd_addr;
            rsp_valid <= mem_rvalid;
            if (mem_rvalid) begin
                rsp_data <= dec.data;
                rsp_err  <= (dec.kind == EV_UNCORR);
            end
        end
    end

    always_comb begin
        case (cfg_addr)
            3'd0:    cfg_rdata = {29'b0, pz_armed, pz_mode};
            3'd1:    cfg_rdata = 32'(pz_target);
            3'd2:    cfg_rdata = {16'b0, last_syn, 6'b0, last_ue, irq};
            3'd3:    cfg_rdata = 32'(last_addr);
            3'd4:    cfg_rdata = {16'(ue_cnt), 16'(ce_cnt)};
            default: cfg_rdata = '0;
        endcase
    end

    p_rd_lat_r2: assert property (@(posedge clk) disable iff (rst)
        mem_rvalid |=> rsp_valid);
    p_ue_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (irq && last_ue));
endmodule

// File: tb/test_ecc_guard.sv
module test_ecc_guard;
    localparam int AW = 8;
    localparam int CW = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_req = 1'b0, rd_req = 1'b0, cfg_we = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [63:0]   wr_data = '0;
    logic [2:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          rsp_valid, rsp_err, mem_we, mem_re, irq;
    logic [63:0]   rsp_data;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [71:0]   mem_wcode;
    logic          mem_rvalid = 1'b0;
    logic [71:0]   mem_rcode = '0;
    logic [31:0]   cfg_rdata;

    // fault port into the storage model
    logic          flt_we = 1'b0;
    logic [AW-1:0] flt_addr = '0;
    logic [71:0]   flt_mask = '0;
    logic [71:0]   store [256];

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic exp_irq = 1'b0, exp_rv = 1'b0;
    int ce_m = 0, ue_m = 0;
    logic last_ue_m = 1'b0;
    logic [7:0] syn_m = '0;
    logic [AW-1:0] addr_m = '0;

    always #10 clk = ~clk;

    ecc_guard #(.ADDR_W(AW), .CNT_W(CW)) i_ecc_guard (
        .clk(clk), .rst(rst),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wcode(mem_wcode),
        .mem_re(mem_re), .mem_raddr(mem_raddr),
        .mem_rvalid(mem_rvalid), .mem_rcode(mem_rcode),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        if (mem_we) store[mem_waddr] <= mem_wcode;
        if (flt_we) store[flt_addr] <= store[flt_addr] ^ flt_mask;
        mem_rvalid <= mem_re;
        if (mem_re) mem_rcode <= store[mem_raddr];
    end

    task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the reference model
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            check("R10 irq per cycle", {71'b0, irq}, {71'b0, exp_irq});
            check("R2 rsp_valid per cycle", {71'b0, rsp_valid}, {71'b0, exp_rv});
        end
    end

    function automatic logic [71:0] ref_code(input logic [63:0] d);
        logic [71:0] pos;
        logic [6:0]  c;
        int k;
        pos = '0;
        k = 0;
        for (int p = 1; p < 72; p++) begin
            if ($countones(p) != 1) begin
                pos[p] = d[k];
                k++;
            end
        end
        for (int j = 0; j < 7; j++) begin
            c[j] = 1'b0;
            for (int p = 1; p < 72; p++) if (p[j]) c[j] ^= pos[p];
        end
        return {^{c, d}, c, d};
    endfunction

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        if (a == 3'd2 && v[0]) exp_irq = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [31:0] v);
        cfg_addr = a;
        #1;
        v = cfg_rdata;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_req = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic flip(input logic [AW-1:0] a, input logic [71:0] m);
        @(negedge clk);
        flt_we = 1'b1; flt_addr = a; flt_mask = m;
        @(negedge clk);
        flt_we = 1'b0;
    endtask

    // read address a; clean_d is the data that was written
    task automatic do_read(input logic [AW-1:0] a, input logic [63:0] clean_d, input string req);
        logic [71:0] w, rc;
        logic [6:0]  s;
        logic        p;
        int          kind;
        logic [63:0] exp_d;
        logic [31:0] v;
        w  = store[a];
        rc = ref_code(w[63:0]);
        s  = rc[70:64] ^ w[70:64];
        p  = ^w;
        if (p && int'(s) <= 71)      kind = 1;
        else if (p || s != 7'd0)     kind = 2;
        else                         kind = 0;
        exp_d = (kind == 1) ? clean_d : w[63:0];
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
        exp_rv = 1'b1;
        if (kind != 0) begin
            exp_irq   = 1'b1;
            last_ue_m = (kind == 2);
            syn_m     = {p, s};
            addr_m    = a;
            if (kind == 1 && ce_m < CMAX) ce_m++;
            if (kind == 2 && ue_m < CMAX) ue_m++;
        end
        @(negedge clk);
        exp_rv = 1'b0;
        check({req, " data"}, {8'b0, rsp_data}, {8'b0, exp_d});
        check({req, " rsp_err"}, {71'b0, rsp_err}, {71'b0, (kind == 2)});
        cfg_read(3'd2, v);
        check("R9 status record", {40'b0, v}, {40'b0, 16'b0, syn_m, 6'b0, last_ue_m, exp_irq});
        cfg_read(3'd3, v);
        check("R9 last address", {40'b0, v}, {40'b0, 24'b0, addr_m});
        cfg_read(3'd4, v);
        check("R11 counters", {40'b0, v}, {40'b0, 16'(ue_m), 16'(ce_m)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [63:0] d;
        int pa [6];
        int pb [6];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check("R12 mem_we", {71'b0, mem_we}, 72'd0);
        check("R12 rsp_valid", {71'b0, rsp_valid}, 72'd0);
        check("R12 irq", {71'b0, irq}, 72'd0);
        for (int a = 0; a < 5; a++) begin
            cfg_read(3'(a), v);
            check("R12 cfg reset", {40'b0, v}, 72'd0);
        end

        // R1, R3, R5, R11: every stored bit flipped in turn
        for (int b = 0; b < 72; b++) begin
            d = {$urandom, $urandom};
            do_write(AW'(b), d);
            check("R1 codeword", store[b], ref_code(d));
            flip(AW'(b), 72'd1 << b);
            do_read(AW'(b), d, "R3 single flip");
        end

        // R10 W1C clear
        cfg_write(3'd2, 32'd1);
        cfg_read(3'd2, v);
        check("R10 irq cleared", {71'b0, v[0]}, 72'd0);

        // R2 clean read keeps the record
        d = 64'h0123_4567_89AB_CDEF;
        do_write(8'd200, d);
        do_read(8'd200, d, "R2 clean read");

        // R4/R5 double flips, including check and parity bits
        pa = '{0, 3, 63, 64, 10, 70};
        pb = '{1, 40, 64, 70, 71, 71};
        for (int i = 0; i < 6; i++) begin
            d = {$urandom, $urandom};
            do_write(AW'(100 + i), d);
            flip(AW'(100 + i), (72'd1 << pa[i]) | (72'd1 << pb[i]));
            do_read(AW'(100 + i), d, "R4 double flip");
        end

        // R5 syndrome outside 1..71 with parity mismatch
        d = 64'hDEAD_BEEF_0000_FFFF;
        do_write(8'd120, d);
        flip(8'd120, (72'd1 << 70) | (72'd1 << 67) | (72'd1 << 71));
        do_read(8'd120, d, "R5 out-of-range syndrome");
        cfg_read(3'd2, v);
        check("R5 syndrome field", {64'b0, v[15:8]}, {64'b0, 8'h80 | 8'd72});

        // R6/R7/R8 single-bit poison
        cfg_write(3'd2, 32'd1);
        cfg_write(3'd1, 32'h20);
        cfg_write(3'd0, 32'd1);
        cfg_read(3'd0, v);
        check("R8 armed readback", {40'b0, v}, {40'b0, 32'd5});
        d = 64'hAAAA_5555_F0F0_0F0F;
        do_write(8'h21, d);
        check("R7 other address clean", store[8'h21], ref_code(d));
        cfg_read(3'd0, v);
        check("R7 still armed", {71'b0, v[2]}, 72'd1);
        do_write(8'h20, d);
        check("R6 single poison", store[8'h20], ref_code(d) ^ 72'd1);
        cfg_read(3'd0, v);
        check("R8 disarmed", {71'b0, v[2]}, 72'd0);
        do_read(8'h20, d, "R6 poisoned read");
        cfg_read(3'd2, v);
        check("R6 poison syndrome", {64'b0, v[15:8]}, {64'b0, 8'h83});
        do_write(8'h20, d);
        check("R8 second write clean", store[8'h20], ref_code(d));

        // R6 double-bit poison
        cfg_write(3'd0, 32'd2);
        do_write(8'h20, d);
        check("R6 double poison", store[8'h20], ref_code(d) ^ 72'd3);
        do_read(8'h20, d, "R6 poisoned double read");
        cfg_read(3'd2, v);
        check("R6 double syndrome", {64'b0, v[15:8]}, {64'b0, 8'h06});

        // R8 mode 0 disarms
        cfg_write(3'd0, 32'd1);
        cfg_write(3'd0, 32'd0);
        do_write(8'h20, d);
        check("R8 mode zero disarm", store[8'h20], ref_code(d));

        // R10 clear then quiet
        cfg_write(3'd2, 32'd1);
        repeat (3) @(negedge clk);
        check("R10 irq after clear", {71'b0, irq}, 72'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule